// File: doc/BRIEF.md
# Shared Reorder-Buffer Capacity Controller

This block keeps the capacity books for a reorder buffer shared by up to `NTHR` hardware threads. It holds one occupancy counter per thread and a total, plus one entry cap per thread. From these it reports how many entries are free for the whole buffer and for each thread. The entry payloads are stored elsewhere. This block only decides how many entries each thread may hold and which thread owns the oldest work.

A two-bit policy input selects the sharing rule, and the rule can be changed at run time. The dynamic rule lets any thread use the whole buffer. The partitioned rule splits the buffer evenly. The threshold rule gives every thread a fixed cap, `THRESH`. The caps are recomputed whenever the policy or the set of active threads changes.

The block also picks the global head: the active, non-empty thread whose head sequence number is the smallest. It raises a commit-possible flag when any active, non-empty thread reports its oldest entry as ready. Allocate and retire are single-cycle strobes, each with a thread id. They are plain control pins with no back-pressure. The pipeline upstream must consult the free counts before it allocates, and `alloc_err` flags any allocation attempted while the buffer is full.

Top module: `rob_share_ctrl`

## Requirements
- R1: After reset, every occupancy is 0, `free_total` equals `DEPTH`, every per-thread free count equals `DEPTH`, `head_vld`, `can_commit` and `alloc_err` are low, and the remembered policy is dynamic.
- R2: With policy code 2'b00 (dynamic), every thread's cap is `DEPTH`.
- R3: With policy code 2'b01 (partitioned), loading the policy sets every cap to floor(`DEPTH`/`NTHR`). After that, each active thread's cap is floor(`DEPTH`/popcount(`active_mask`)), while inactive threads keep their caps. A mask of all zeros changes nothing.
- R4: With policy code 2'b10 (threshold), loading the policy sets every cap to `THRESH`. When exactly one thread is active, that thread's cap becomes `DEPTH`.
- R5: Policy code 2'b11 raises `policy_err` in the same cycle, and all caps hold their values while the code persists.
- R6: The per-thread free count is the cap minus the occupancy, and it is 0 when the occupancy exceeds the cap. `free_total` is `DEPTH` minus the total occupancy.
- R7: An accepted allocate adds one to the named thread's occupancy, and an accepted retire subtracts one. Both counts are visible one cycle later. When both strobes arrive in the same cycle, both take effect, even when they name the same thread.
- R8: An allocate while the total occupancy equals `DEPTH` raises `alloc_err` in that cycle and is dropped. A retire that names a thread with zero occupancy is ignored.
- R9: `head_vld` is high only if some active thread has a non-zero occupancy. `head_tid` and `head_sn` then give the thread with the smallest head sequence number, and the lowest thread id wins a tie.
- R10: `can_commit` is high when at least one thread is active, non-empty and has its `head_rdy` bit set.
- R11: A change of policy or of `active_mask` takes effect on the caps at the next clock edge. A policy change first loads that policy's base caps and then applies the active-set rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy | input | 2 | Sharing rule: 00 dynamic, 01 partitioned, 10 threshold, 11 invalid |
| active_mask | input | NTHR | One bit per thread that is currently running |
| alloc_vld | input | 1 | Allocate strobe |
| alloc_tid | input | TIDW | Thread of the allocation |
| retire_vld | input | 1 | Retire strobe |
| retire_tid | input | TIDW | Thread of the retirement |
| head_seq | input | NTHR*SEQW | Head sequence number of each thread, thread 0 in the low bits |
| head_rdy | input | NTHR | Oldest entry of each thread is ready to commit |
| thr_occ | output | NTHR*CNTW | Occupancy of each thread |
| thr_free | output | NTHR*CNTW | Free entries of each thread |
| free_total | output | CNTW | Free entries of the whole buffer |
| head_vld | output | 1 | A global head exists |
| head_tid | output | TIDW | Thread owning the global head |
| head_sn | output | SEQW | Sequence number of the global head |
| can_commit | output | 1 | Some active thread can commit |
| alloc_err | output | 1 | Allocate attempted while full |
| policy_err | output | 1 | Invalid policy code |

## Verification
The bench aims at several corner cases, and each one exposes a different mistake:

- **Filling the buffer to the last entry, then allocating again, alone and together with a retire.** A design with an off-by-one full test would wrap `free_total` or miss `alloc_err`.
- **Shrinking the active set under the partitioned rule while a thread holds more than its new share.** A design without saturation would report a huge per-thread free count. A design that recomputed inactive threads would change their caps.
- **Leaving a single thread active under the threshold rule, then switching to the invalid code.** These expose a missing whole-buffer grant and caps that drift while `policy_err` is high.
- **Ties between head sequence numbers, and non-empty threads that are inactive.** These catch a head selector that favours the wrong thread or counts threads it should skip.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [1:0] {
    POL_DYN  = 2'b00,
    POL_PART = 2'b01,
    POL_THR  = 2'b10,
    POL_BAD  = 2'b11
  } pol_e;
endpackage

// File: rtl/rsc_occupancy.sv
module rsc_occupancy #(
  parameter int NTHR  = 4,
  parameter int DEPTH = 32,
  parameter int CNTW  = 6,
  parameter int TIDW  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_vld,
  input  logic [TIDW-1:0] alloc_tid,
  input  logic            retire_vld,
  input  logic [TIDW-1:0] retire_tid,
  output logic [CNTW-1:0] occ [NTHR],
  output logic [CNTW-1:0] total,
  output logic            alloc_err
);
  logic full, acc, ret, ret_nz;

  assign full = (total == CNTW'(DEPTH));
  assign acc  = alloc_vld && !full && (int'(alloc_tid) < NTHR);

  always_comb begin
    ret_nz = 1'b0;
    for (int i = 0; i < NTHR; i++)
      if (retire_tid == TIDW'(i) && occ[i] != '0) ret_nz = 1'b1;
  end

  // R8: retiring an empty thread is ignored
  assign ret       = retire_vld && ret_nz;
  assign alloc_err = alloc_vld && full;

  for (genvar g = 0; g < NTHR; g++) begin : g_cnt
    logic up, dn;
    assign up = acc && (alloc_tid == TIDW'(g));
    assign dn = ret && (retire_tid == TIDW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) occ[g] <= '0;
      else        occ[g] <= occ[g] + CNTW'(up) - CNTW'(dn);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) total <= '0;
    else        total <= total + CNTW'(acc) - CNTW'(ret);
  end
endmodule

// File: rtl/rsc_cap_ctrl.sv
module rsc_cap_ctrl
  import rsc_pkg::*;
#(
  parameter int NTHR   = 4,
  parameter int DEPTH  = 32,
  parameter int THRESH = 12,
  parameter int CNTW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      policy,
  input  logic [NTHR-1:0] active_mask,
  output logic [CNTW-1:0] caps [NTHR],
  output logic            policy_err
);
  localparam int ACW = $clog2(NTHR + 1);

  pol_e            pol, prev_pol;
  logic [NTHR-1:0] prev_mask;
  logic [CNTW-1:0] cap_d [NTHR];
  logic [CNTW-1:0] base, share;
  logic [ACW-1:0]  act_cnt;

  assign pol        = pol_e'(policy);
  assign policy_err = (pol == POL_BAD);

  always_comb begin
    act_cnt = '0;
    for (int i = 0; i < NTHR; i++) act_cnt = act_cnt + ACW'(active_mask[i]);
    share = '0;
    for (int k = 1; k <= NTHR; k++)
      if (act_cnt == ACW'(k)) share = CNTW'(DEPTH / k);
    case (pol)
      POL_PART: base = CNTW'(DEPTH / NTHR);
      POL_THR:  base = CNTW'(THRESH);
      default:  base = CNTW'(DEPTH);
    endcase
  end

  always_comb begin
    for (int i = 0; i < NTHR; i++) cap_d[i] = caps[i];
    if (pol != POL_BAD) begin
      if (pol != prev_pol)
        for (int i = 0; i < NTHR; i++) cap_d[i] = base;
      if (pol != prev_pol || active_mask != prev_mask) begin
        for (int i = 0; i < NTHR; i++) begin
          if (pol == POL_PART && active_mask[i] && act_cnt != '0)
            cap_d[i] = share;
          if (pol == POL_THR && active_mask[i] && act_cnt == ACW'(1))
            cap_d[i] = CNTW'(DEPTH);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_pol  <= POL_DYN;
      prev_mask <= '0;
      for (int i = 0; i < NTHR; i++) caps[i] <= CNTW'(DEPTH);
    end else begin
      prev_pol  <= pol;
      prev_mask <= active_mask;
      for (int i = 0; i < NTHR; i++) caps[i] <= cap_d[i];
    end
  end
endmodule

// File: rtl/rsc_head_pick.sv
module rsc_head_pick #(
  parameter int NTHR = 4,
  parameter int CNTW = 6,
  parameter int SEQW = 16,
  parameter int TIDW = 2
) (
  input  logic [NTHR-1:0]      active_mask,
  input  logic [CNTW-1:0]      occ [NTHR],
  input  logic [NTHR*SEQW-1:0] head_seq,
  input  logic [NTHR-1:0]      head_rdy,
  output logic                 head_vld,
  output logic [TIDW-1:0]      head_tid,
  output logic [SEQW-1:0]      head_sn,
  output logic                 can_commit
);
  logic [NTHR-1:0] live;

  for (genvar g = 0; g < NTHR; g++) begin : g_live
    assign live[g] = active_mask[g] && (occ[g] != '0);
  end

  assign can_commit = |(live & head_rdy);

  always_comb begin
    head_vld = 1'b0;
    head_tid = '0;
    head_sn  = '0;
    for (int i = 0; i < NTHR; i++) begin
      if (live[i] && (!head_vld || head_seq[i*SEQW +: SEQW] < head_sn)) begin
        head_vld = 1'b1;
        head_tid = TIDW'(i);
        head_sn  = head_seq[i*SEQW +: SEQW];
      end
    end
  end
endmodule

// File: rtl/rob_share_ctrl.sv
module rob_share_ctrl #(
  parameter int NTHR   = 4,
  parameter int DEPTH  = 32,
  parameter int THRESH = 12,
  parameter int SEQW   = 16,
  localparam int CNTW  = $clog2(DEPTH + 1),
  localparam int TIDW  = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           policy,
  input  logic [NTHR-1:0]      active_mask,
  input  logic                 alloc_vld,
  input  logic [TIDW-1:0]      alloc_tid,
  input  logic                 retire_vld,
  input  logic [TIDW-1:0]      retire_tid,
  input  logic [NTHR*SEQW-1:0] head_seq,
  input  logic [NTHR-1:0]      head_rdy,
  output logic [NTHR*CNTW-1:0] thr_occ,
  output logic [NTHR*CNTW-1:0] thr_free,
  output logic [CNTW-1:0]      free_total,
  output logic                 head_vld,
  output logic [TIDW-1:0]      head_tid,
  output logic [SEQW-1:0]      head_sn,
  output logic                 can_commit,
  output logic                 alloc_err,
  output logic                 policy_err
);
  logic [CNTW-1:0] occ  [NTHR];
  logic [CNTW-1:0] caps [NTHR];
  logic [CNTW-1:0] total;

  rsc_occupancy #(.NTHR(NTHR), .DEPTH(DEPTH), .CNTW(CNTW), .TIDW(TIDW)) u_occ (
    .clk(clk), .rst_n(rst_n),
    .alloc_vld(alloc_vld), .alloc_tid(alloc_tid),
    .retire_vld(retire_vld), .retire_tid(retire_tid),
    .occ(occ), .total(total), .alloc_err(alloc_err)
  );

  rsc_cap_ctrl #(.NTHR(NTHR), .DEPTH(DEPTH), .THRESH(THRESH), .CNTW(CNTW)) u_cap (
    .clk(clk), .rst_n(rst_n), .policy(policy), .active_mask(active_mask),
    .caps(caps), .policy_err(policy_err)
  );

  rsc_head_pick #(.NTHR(NTHR), .CNTW(CNTW), .SEQW(SEQW), .TIDW(TIDW)) u_head (
    .active_mask(active_mask), .occ(occ), .head_seq(head_seq), .head_rdy(head_rdy),
    .head_vld(head_vld), .head_tid(head_tid), .head_sn(head_sn),
    .can_commit(can_commit)
  );

  assign free_total = CNTW'(DEPTH) - total;

  for (genvar g = 0; g < NTHR; g++) begin : g_out
    assign thr_occ[g*CNTW +: CNTW]  = occ[g];
    assign thr_free[g*CNTW +: CNTW] = (caps[g] > occ[g]) ? caps[g] - occ[g] : '0;
  end
endmodule

// File: rtl/rob_share_chk.sv
module rob_share_chk #(
  parameter int NTHR  = 4,
  parameter int DEPTH = 32,
  parameter int CNTW  = 6,
  parameter int TIDW  = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NTHR-1:0] active_mask,
  input logic            alloc_vld,
  input logic            retire_vld,
  input logic [CNTW-1:0] free_total,
  input logic            head_vld,
  input logic [TIDW-1:0] head_tid,
  input logic            can_commit,
  input logic            alloc_err
);
  AST_FULL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_vld && free_total == '0) |-> alloc_err); // R8
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_vld && free_total == '0 && !retire_vld) |=> (free_total == '0)); // R8
  AST_ALLOC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_vld && free_total != '0 && !retire_vld) |=> (free_total == $past(free_total) - CNTW'(1))); // R7
  AST_FREE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    free_total <= CNTW'(DEPTH)); // R6
  AST_HEAD_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    head_vld |-> active_mask[head_tid]); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (active_mask == '0) |-> (!head_vld && !can_commit)); // R10
  AST_COMMIT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    can_commit |-> (free_total != CNTW'(DEPTH) && head_vld)); // R10
endmodule

bind rob_share_ctrl rob_share_chk #(.NTHR(NTHR), .DEPTH(DEPTH), .CNTW(CNTW), .TIDW(TIDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .active_mask(active_mask), .alloc_vld(alloc_vld),
  .retire_vld(retire_vld), .free_total(free_total), .head_vld(head_vld),
  .head_tid(head_tid), .can_commit(can_commit), .alloc_err(alloc_err)
);

// File: tb/sim_rob_share_ctrl.sv
module sim_rob_share_ctrl;
  localparam int NTHR = 4, DEPTH = 32, THRESH = 12, SEQW = 16, CNTW = 6, TIDW = 2;

  logic clk = 0, rst_n = 0;
  logic [1:0] policy = 0;
  logic [NTHR-1:0] active_mask = 0, head_rdy = 0;
  logic alloc_vld = 0, retire_vld = 0;
  logic [TIDW-1:0] alloc_tid = 0, retire_tid = 0;
  logic [NTHR*SEQW-1:0] head_seq = 0;
  logic [NTHR*CNTW-1:0] thr_occ, thr_free;
  logic [CNTW-1:0] free_total;
  logic head_vld, can_commit, alloc_err, policy_err;
  logic [TIDW-1:0] head_tid;
  logic [SEQW-1:0] head_sn;

  int checks = 0, failures = 0;
  int m_occ[NTHR], m_cap[NTHR], m_total, m_ppol, m_pmask;

  always #10 clk = ~clk;

  rob_share_ctrl #(.NTHR(NTHR), .DEPTH(DEPTH), .THRESH(THRESH), .SEQW(SEQW)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model, updated on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_occ[i]) begin m_occ[i] = 0; m_cap[i] = DEPTH; end
      m_total = 0; m_ppol = 0; m_pmask = 0;
    end else begin
      int cnt, pol, mask;
      bit acc, ret;
      pol = policy; mask = active_mask; cnt = $countones(active_mask);
      if (pol != 3) begin
        if (pol != m_ppol)
          foreach (m_cap[i]) m_cap[i] = (pol == 1) ? DEPTH / NTHR : (pol == 2) ? THRESH : DEPTH;
        if (pol != m_ppol || mask != m_pmask)
          foreach (m_cap[i]) if (mask[i]) begin
            if (pol == 1) m_cap[i] = DEPTH / cnt;
            if (pol == 2 && cnt == 1) m_cap[i] = DEPTH;
          end
      end
      m_ppol = pol; m_pmask = mask;
      acc = alloc_vld && m_total < DEPTH;
      ret = retire_vld && m_occ[retire_tid] > 0;
      if (acc) m_occ[alloc_tid]++;
      if (ret) m_occ[retire_tid]--;
      m_total += int'(acc) - int'(ret);
    end
  end

  task automatic compare();
    int bt, bs, ok_commit;
    string ptag;
    ptag = (policy == 0) ? "R2" : (policy == 1) ? "R3" : (policy == 2) ? "R4" : "R5";
    chk(free_total == DEPTH - m_total, "R6 free_total", free_total, DEPTH - m_total);
    for (int i = 0; i < NTHR; i++) begin
      int ef;
      ef = (m_cap[i] > m_occ[i]) ? m_cap[i] - m_occ[i] : 0;
      chk(thr_occ[i*CNTW +: CNTW] == m_occ[i], "R7 occupancy", thr_occ[i*CNTW +: CNTW], m_occ[i]);
      chk(thr_free[i*CNTW +: CNTW] == ef, {ptag, " R6 thread free"}, thr_free[i*CNTW +: CNTW], ef);
    end
    bt = -1; bs = 0; ok_commit = 0;
    for (int i = 0; i < NTHR; i++)
      if (active_mask[i] && m_occ[i] > 0) begin
        if (head_rdy[i]) ok_commit = 1;
        if (bt < 0 || int'(head_seq[i*SEQW +: SEQW]) < bs) begin
          bt = i; bs = head_seq[i*SEQW +: SEQW];
        end
      end
    chk(head_vld == (bt >= 0), "R9 head_vld", head_vld, bt >= 0);
    if (bt >= 0) begin
      chk(head_tid == bt, "R9 head_tid", head_tid, bt);
      chk(head_sn == bs, "R9 head_sn", head_sn, bs);
    end
    chk(can_commit == ok_commit, "R10 can_commit", can_commit, ok_commit);
    chk(alloc_err == (alloc_vld && m_total == DEPTH), "R8 alloc_err", alloc_err, alloc_vld && m_total == DEPTH);
    chk(policy_err == (policy == 3), "R5 policy_err", policy_err, policy == 3);
  endtask

  task automatic step(input int pol, input int mask, input bit av, input int at, input bit rv, input int rt);
    @(negedge clk);
    policy = pol[1:0]; active_mask = mask[NTHR-1:0];
    alloc_vld = av; alloc_tid = at[TIDW-1:0];
    retire_vld = rv; retire_tid = rt[TIDW-1:0];
    #1 compare();
  endtask

  initial begin
    #(20ns * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    head_seq = {16'd40, 16'd30, 16'd20, 16'd10};
    head_rdy = 4'b0100;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(free_total == DEPTH, "R1 reset free_total", free_total, DEPTH);
    chk(thr_free == {NTHR{CNTW'(DEPTH)}}, "R1 reset thread free", 0, 0);
    chk(thr_occ == '0, "R1 reset occupancy", thr_occ, 0);
    chk(!head_vld && !can_commit && !alloc_err, "R1 reset flags", head_vld, 0);
    // R2 dynamic, fill to full, then overflow (R8)
    for (int k = 0; k < DEPTH; k++) step(0, 4'b1111, 1, k % 4, 0, 0);
    step(0, 4'b1111, 1, 1, 0, 0);
    chk(alloc_err == 1, "R8 alloc while full", alloc_err, 1);
    step(0, 4'b1111, 1, 2, 1, 2);   // R7 both strobes at full
    step(0, 4'b1111, 1, 3, 1, 3);
    // drain
    for (int k = 0; k < DEPTH + 4; k++) step(0, 4'b1111, 0, 0, 1, k % 4);
    step(0, 4'b1111, 0, 0, 1, 0);   // R8 retire of empty thread ignored
    chk(free_total == DEPTH, "R8 empty retire ignored", free_total, DEPTH);
    // R3 partitioned, thread 0 over-filled, then shrink active set
    for (int k = 0; k < 12; k++) step(1, 4'b1111, 1, 0, 0, 0);
    step(1, 4'b0011, 0, 0, 0, 0);
    chk(thr_free[0 +: CNTW] == 0, "R11 cap not yet updated, R6 saturation", thr_free[0 +: CNTW], 0);
    step(1, 4'b0011, 0, 0, 0, 0);
    chk(thr_free[0 +: CNTW] == 4, "R11 R3 new share", thr_free[0 +: CNTW], 4);
    step(1, 4'b0000, 0, 0, 0, 0);
    step(1, 4'b0000, 0, 0, 0, 0);
    // R4 threshold
    step(2, 4'b1111, 0, 0, 0, 0);
    step(2, 4'b0100, 0, 0, 0, 0);
    step(2, 4'b0100, 1, 2, 0, 0);
    chk(thr_free[2*CNTW +: CNTW] == DEPTH, "R4 single active whole buffer", thr_free[2*CNTW +: CNTW], DEPTH);
    // R5 invalid code freezes caps
    step(3, 4'b1111, 0, 0, 0, 0);
    step(3, 4'b0001, 0, 0, 0, 0);
    step(3, 4'b0001, 0, 0, 0, 0);
    chk(thr_free[2*CNTW +: CNTW] == DEPTH - 1, "R5 caps frozen", thr_free[2*CNTW +: CNTW], DEPTH - 1);
    // R9 ties
    head_seq = {16'd5, 16'd5, 16'd9, 16'd5};
    step(0, 4'b1110, 1, 1, 0, 0);
    step(0, 4'b1110, 1, 3, 0, 0);
    step(0, 4'b1110, 0, 0, 0, 0);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      int pol, mask;
      pol = (n / 97) % 4; mask = $urandom_range(0, 15);
      if (n % 7 != 0) mask = active_mask;
      for (int i = 0; i < NTHR; i++) head_seq[i*SEQW +: SEQW] = SEQW'($urandom_range(0, 7));
      head_rdy = NTHR'($urandom_range(0, 15));
      step(pol, mask, $urandom_range(0, 2) != 0, $urandom_range(0, 3),
           $urandom_range(0, 2) == 0, $urandom_range(0, 3));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule